// File: doc/BRIEF.md
# Three-Wire Control Bus Register Slave

This block is a register slave on a three-wire microcontroller control bus made of a bus clock, a mode line and a shared data line. While the mode line is low, the master sends an 8-bit device-address byte. This byte selects a device by its two strap inputs and sets the transfer type. While the mode line is high, the master sends data bytes, or, after a read-type address, the slave drives its response onto the data line. All three bus lines are brought into the system clock domain through synchronizers and edge detectors. Bits are taken on rising bus-clock edges, and response bits are changed on falling edges.

A write uses two phases. The address phase selects the device with a write-type address. The data phase then carries a register byte with a read/write flag and a 7-bit register address, followed by two data bytes. A read uses three steps. First a prepare-read stores the register address. Then a read-type address phase follows. In the next data phase the slave drives back the prepared address with a validity flag, followed by the 16-bit register value. The register file holds `REG_COUNT` 16-bit registers at `REG_BASE` and up. Every other register address counts as unimplemented.

Top module: `twc_slave`

## Requirements
- R1: After reset the slave ignores all bus traffic until it has seen one rising edge of the bus clock. That wake-up edge carries no bit. After the wake-up, no further wake-up is needed until the next reset.
- R2: While the mode line is low, the slave samples the first 8 bits on rising bus-clock edges and ignores any later bits. The bit tagged 0 is first on the wire. The device matches when bit 2 equals strap bit 0, bit 3 equals strap bit 1, and bits 4..7 are 1,0,0,0. A non-matching address makes the slave ignore the following data phase.
- R3: The transfer type is set by address bits (0,1). The value (0,1) means write or prepare-read, and (1,1) means read. The values (0,0) and (1,0) make the slave ignore the following data phase.
- R4: After a write-type address, the first data byte is a flag and a register address. The flag comes first on the wire: 0 means write and 1 means prepare-read. The seven address bits follow, A6 first and A0 last. A prepare-read stores the register address and ignores any later bytes in that phase.
- R5: A write takes two data bytes after the register byte. Each byte is sent MSB first, D15..D8 and then D7..D0. The value is stored after the second byte. Further bytes in the same data phase are ignored, and the register address does not advance.
- R6: A write to an unimplemented register address (outside REG_BASE..REG_BASE+REG_COUNT-1, default 0x10..0x13) changes no register.
- R7: In the data phase after a matching read-type address, the slave drives 24 bits. These are the flag (0 = valid), the prepared address A6..A0, and then D15..D0. The first bit is on the line before the first bus clock. Each later bit appears after the falling edge that follows the previous rising edge.
- R8: A read of an unimplemented register returns flag 1 and data 0x0000.
- R9: The output enable is high only while a read response is being driven. It drops after the falling edge that follows the 24th bit, and on any change of the mode line. It stays low during write and address phases.
- R10: After reset the output enable and the data output are low, every register reads 0x0000, and the prepared address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Bus clock, asynchronous |
| bus_mode_i | input | 1 | Mode line: low = address phase, high = data phase |
| bus_data_i | input | 1 | Data line as seen at the pad |
| strap_i | input | 2 | Device-address straps: [0] matches address bit 2, [1] matches address bit 3 |
| bus_data_o | output | 1 | Response bit to drive onto the data line |
| bus_data_oe | output | 1 | High while the slave drives the data line |

## Verification
A table of register/value pairs is written, prepared and read back. The pairs cover each implemented register, single-bit and alternating data patterns, and addresses just below and just above the implemented range. This separates correct storage and bit order from byte swaps and off-by-one range checks. Directed sequences then send:
- a transfer without the wake-up pulse,
- wrong straps and changed straps,
- the two ignored type codes,
- a prepare-read followed by stray bytes,
- a write followed by extra byte pairs,
- a read cut short by a mode change.

Each of these is told apart by a later read through the bus, or by the level of the output enable.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_AW   = 7;
  localparam int REG_DW   = 16;
  // Bits 4..7 of the device byte, as they sit after an MSB-side shift-in.
  localparam logic [3:0] DEV_FIXED  = 4'b1000;
  // {bit0, bit1} of the device byte.
  localparam logic [1:0] TYPE_WRITE = 2'b01;
  localparam logic [1:0] TYPE_READ  = 2'b11;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_WRITE = 2'd1,
    SEL_READ  = 2'd2
  } sel_t;
endpackage

// File: rtl/twc_sync.sv
module twc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= stg[STAGES-1];
  end

  assign level_o = stg[STAGES-1];
  assign rise_o  = stg[STAGES-1] & ~prev;
  assign fall_o  = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/twc_regfile.sv
module twc_regfile #(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int COUNT = 4,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [AW:0] CNT = COUNT[AW:0];

  logic [DW-1:0] mem [COUNT];
  logic [AW-1:0] wr_off, rd_off;
  logic          wr_hit, rd_hit;

  assign wr_off = wr_addr - BASE;
  assign rd_off = rd_addr - BASE;
  assign wr_hit = {1'b0, wr_off} < CNT;
  assign rd_hit = {1'b0, rd_off} < CNT;

  for (genvar g = 0; g < COUNT; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) mem[g] <= '0;
      else if (wr_en && wr_hit && wr_off[IDX_W-1:0] == IDX_W'(g)) mem[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_hit ? mem[rd_off[IDX_W-1:0]] : '0;
      rd_valid <= rd_hit;
    end
  end
endmodule

// File: rtl/twc_slave.sv
module twc_slave
  import twc_pkg::*;
#(
  parameter int REG_COUNT = 4,
  parameter logic [REG_AW-1:0] REG_BASE = 7'h10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_clk_i,
  input  logic       bus_mode_i,
  input  logic       bus_data_i,
  input  logic [1:0] strap_i,
  output logic       bus_data_o,
  output logic       bus_data_oe
);
  localparam int TXW   = BYTE_W + REG_DW;
  localparam int TXC_W = $clog2(TXW + 1);

  logic [2:0] lvl, rise, fall;
  logic bclk_rise, bclk_fall, mode_s, mode_rise, mode_fall, din;

  twc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({bus_data_i, bus_mode_i, bus_clk_i}),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign bclk_rise = rise[0];
  assign bclk_fall = fall[0];
  assign mode_s    = lvl[1];
  assign mode_rise = rise[1];
  assign mode_fall = fall[1];
  assign din       = lvl[2];

  logic              awake;
  sel_t              sel;
  logic [7:0]        sh;
  logic [7:0]        sh_next;
  logic [3:0]        bit_cnt;
  logic [1:0]        byte_idx;
  logic              rw_flag;
  logic [7:0]        hi_byte;
  logic [REG_AW-1:0] prep_addr;
  logic [TXW-1:0]    tx;
  logic [TXW-1:0]    rd_word;
  logic [TXC_W-1:0]  tx_left;
  logic              tx_armed;
  logic              oe, dout;
  logic              wr_en;
  logic [REG_AW-1:0] wr_addr;
  logic [REG_DW-1:0] wr_data;
  logic [REG_DW-1:0] rd_data;
  logic              rd_valid;

  twc_regfile #(.AW(REG_AW), .DW(REG_DW), .COUNT(REG_COUNT), .BASE(REG_BASE)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(prep_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic sel_t decode(input logic [7:0] a, input logic [1:0] s);
    logic hit;
    hit = (a[3:0] == DEV_FIXED) && (a[5] == s[0]) && (a[4] == s[1]);
    if (hit && a[7:6] == TYPE_WRITE)     return SEL_WRITE;
    else if (hit && a[7:6] == TYPE_READ) return SEL_READ;
    else                                 return SEL_NONE;
  endfunction

  assign sh_next = {sh[6:0], din};
  assign rd_word = {~rd_valid, prep_addr, rd_valid ? rd_data : {REG_DW{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      awake <= 1'b0; sel <= SEL_NONE; sh <= '0; bit_cnt <= '0; byte_idx <= '0;
      rw_flag <= 1'b0; hi_byte <= '0; prep_addr <= '0; tx <= '0; tx_left <= '0;
      tx_armed <= 1'b0; oe <= 1'b0; dout <= 1'b0; wr_en <= 1'b0;
      wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!awake) begin
        if (bclk_rise) awake <= 1'b1;
      end else if (mode_rise || mode_fall) begin
        bit_cnt <= '0; byte_idx <= '0; oe <= 1'b0; dout <= 1'b0;
        tx_left <= '0; tx_armed <= 1'b0;
        if (mode_fall) sel <= SEL_NONE;
        else if (sel == SEL_READ) begin
          tx      <= rd_word;
          dout    <= rd_word[TXW-1];
          oe      <= 1'b1;
          tx_left <= TXC_W'(TXW);
        end
      end else if (bclk_rise) begin
        if (!mode_s) begin
          if (bit_cnt != 4'd8) begin
            sh      <= sh_next;
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == 4'd7) sel <= decode(sh_next, strap_i);
          end
        end else if (sel == SEL_WRITE && byte_idx != 2'd3) begin
          sh <= sh_next;
          if (bit_cnt == 4'd7) begin
            bit_cnt  <= '0;
            byte_idx <= byte_idx + 2'd1;
            case (byte_idx)
              2'd0: begin
                rw_flag <= sh_next[7];
                wr_addr <= sh_next[6:0];
                if (sh_next[7]) prep_addr <= sh_next[6:0];
              end
              2'd1: hi_byte <= sh_next;
              2'd2: if (!rw_flag) begin
                wr_en   <= 1'b1;
                wr_data <= {hi_byte, sh_next};
              end
              default: ;
            endcase
          end else begin
            bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (oe && tx_left != '0) begin
          tx_left  <= tx_left - TXC_W'(1);
          tx_armed <= 1'b1;
        end
      end else if (bclk_fall && oe && tx_armed) begin
        tx_armed <= 1'b0;
        if (tx_left == '0) begin
          oe   <= 1'b0;
          dout <= 1'b0;
        end else begin
          tx   <= {tx[TXW-2:0], 1'b0};
          dout <= tx[TXW-2];
        end
      end
    end
  end

  assign bus_data_o  = dout;
  assign bus_data_oe = oe;
endmodule

// File: rtl/twc_slave_chk.sv
module twc_slave_chk
  import twc_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic awake,
  input logic oe,
  input logic dout,
  input logic bclk_fall,
  input logic mode_s,
  input logic mode_fall,
  input logic wr_en,
  input sel_t sel
);
  assert_wake_gate_R1: assert property (@(posedge clk) disable iff (rst)
    !awake |-> (!oe && !wr_en));

  assert_write_needs_sel_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> sel == SEL_WRITE);

  assert_oe_only_read_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> sel == SEL_READ);

  // R7: the response bit only moves after a bus-clock falling edge
  assert_dout_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (oe && $past(oe) && !$past(bclk_fall)) |-> $stable(dout));

  assert_mode_release_R9: assert property (@(posedge clk) disable iff (rst)
    mode_fall |=> !oe);

  assert_oe_in_data_R9: assert property (@(posedge clk) disable iff (rst)
    (oe && !mode_fall) |-> mode_s);
endmodule

bind twc_slave twc_slave_chk chk_i (
  .clk(clk), .rst(rst), .awake(awake), .oe(oe), .dout(dout),
  .bclk_fall(bclk_fall), .mode_s(mode_s), .mode_fall(mode_fall),
  .wr_en(wr_en), .sel(sel)
);

// File: tb/twc_slave_tb_top.sv
`timescale 1ns/1ps
module twc_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b1, bmode = 1'b1, bdata = 1'b0;
  logic [1:0] strap = 2'b00;
  logic dout, oe;
  int total = 0, bad = 0;
  bit done = 0;
  localparam int HP = 8;

  always #2.5 clk = ~clk;

  twc_slave dut_i (
    .clk(clk), .rst(rst), .bus_clk_i(bclk), .bus_mode_i(bmode),
    .bus_data_i(bdata), .strap_i(strap), .bus_data_o(dout), .bus_data_oe(oe)
  );

  // {expect_valid, reg_addr[6:0], data[15:0]}
  localparam logic [23:0] VEC [6] = '{
    {1'b1, 7'h10, 16'hA55A},
    {1'b1, 7'h13, 16'h0001},
    {1'b1, 7'h11, 16'h8000},
    {1'b1, 7'h12, 16'hFFFF},
    {1'b0, 7'h14, 16'h1234},
    {1'b0, 7'h0F, 16'hC3C3}
  };

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(logic b);
    bclk = 1'b0; bdata = b; hold(HP);
    bclk = 1'b1; hold(HP);
  endtask

  task automatic byte_out(logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic set_mode(logic m);
    bmode = m; hold(HP);
  endtask

  function automatic logic [7:0] dev(logic t0, logic t1, logic [1:0] s);
    return {t0, t1, s[0], s[1], 4'b1000};
  endfunction

  task automatic do_write_t(logic t0, logic t1, logic [1:0] s, logic [6:0] a, logic [15:0] d);
    set_mode(1'b0); byte_out(dev(t0, t1, s));
    set_mode(1'b1); byte_out({1'b0, a}); byte_out(d[15:8]); byte_out(d[7:0]);
  endtask

  task automatic do_write(logic [1:0] s, logic [6:0] a, logic [15:0] d);
    do_write_t(1'b0, 1'b1, s, a, d);
  endtask

  task automatic do_prep(logic [1:0] s, logic [6:0] a);
    set_mode(1'b0); byte_out(dev(1'b0, 1'b1, s));
    set_mode(1'b1); byte_out({1'b1, a});
  endtask

  task automatic do_read(input logic [1:0] s, input int nbits, output logic [23:0] w,
                         output int oe_miss, output logic oe_end);
    set_mode(1'b0); byte_out(dev(1'b1, 1'b1, s));
    set_mode(1'b1);
    w = '0; oe_miss = 0;
    for (int i = 0; i < nbits; i++) begin
      bclk = 1'b0; hold(HP);
      if (oe !== 1'b1) oe_miss++;
      w = {w[22:0], dout};
      bclk = 1'b1; hold(HP);
    end
    if (nbits == 24) begin
      bclk = 1'b0; hold(HP);
      oe_end = oe;
      bclk = 1'b1; hold(HP);
    end else begin
      set_mode(1'b0);
      oe_end = oe;
    end
  endtask

  task automatic read_reg(logic [1:0] s, logic [6:0] a, output logic [23:0] w);
    int m; logic e;
    do_prep(s, a);
    do_read(s, 24, w, m, e);
  endtask

  initial begin
    logic [23:0] w, exp;
    int miss;
    logic oe_end;
    hold(10);
    rst = 1'b0;
    hold(4);
    chk("R10 oe after reset", oe, 0);
    chk("R10 dout after reset", dout, 0);

    // R1: first clock pulse only wakes the slave, so this write is misaligned and lost
    do_write(2'b00, 7'h12, 16'hBEEF);
    read_reg(2'b00, 7'h12, w);
    chk("R1 write before wake ignored (R10 reset value)", w, {1'b0, 7'h12, 16'h0000});

    // Table: R5 stored write, R6 out-of-range discard, R7 framing, R8 invalid flag, R9 release
    for (int i = 0; i < 6; i++) begin
      logic v; logic [6:0] a; logic [15:0] d;
      v = VEC[i][23]; a = VEC[i][22:16]; d = VEC[i][15:0];
      do_write(2'b00, a, d);
      chk("R9 oe low after write phase", oe, 0);
      do_prep(2'b00, a);
      do_read(2'b00, 24, w, miss, oe_end);
      exp = v ? {1'b0, a, d} : {1'b1, a, 16'h0000};
      chk(v ? "R5 R7 read back word" : "R6 R8 invalid read word", w, exp);
      chk("R9 oe held through 24 bits", miss, 0);
      chk("R9 oe released after last bit", oe_end, 0);
    end
    read_reg(2'b00, 7'h12, w);
    chk("R6 in-range neighbour untouched by out-of-range writes", w, {1'b0, 7'h12, 16'hFFFF});

    // R2: wrong straps in the address byte
    do_write(2'b01, 7'h10, 16'h1111);
    do_write(2'b10, 7'h10, 16'h2222);
    read_reg(2'b00, 7'h10, w);
    chk("R2 strap mismatch write ignored", w, {1'b0, 7'h10, 16'hA55A});

    // R2: new strap setting
    strap = 2'b10; hold(4);
    do_write(2'b10, 7'h12, 16'h5AA5);
    read_reg(2'b10, 7'h12, w);
    chk("R2 strap 10 device matches", w, {1'b0, 7'h12, 16'h5AA5});
    do_read(2'b00, 24, w, miss, oe_end);
    chk("R2 old straps get no response", miss, 24);
    strap = 2'b00; hold(4);

    // R3: ignored type codes
    do_write_t(1'b0, 1'b0, 2'b00, 7'h10, 16'h7777);
    do_write_t(1'b1, 1'b0, 2'b00, 7'h10, 16'h6666);
    read_reg(2'b00, 7'h10, w);
    chk("R3 type 00 and 10 ignored", w, {1'b0, 7'h10, 16'hA55A});

    // R4: prepare-read with stray bytes must not write
    do_prep(2'b00, 7'h13);
    byte_out(8'hDE); byte_out(8'hAD);
    do_read(2'b00, 24, w, miss, oe_end);
    chk("R4 prepare-read stores address and does not write", w, {1'b0, 7'h13, 16'h0001});

    // R5: extra byte pairs in one phase are ignored, no address advance
    do_write(2'b00, 7'h11, 16'h1111);
    byte_out(8'h22); byte_out(8'h22);
    read_reg(2'b00, 7'h11, w);
    chk("R5 extra bytes ignored", w, {1'b0, 7'h11, 16'h1111});
    read_reg(2'b00, 7'h12, w);
    chk("R5 no auto increment", w, {1'b0, 7'h12, 16'h5AA5});

    // R9: mode change cuts a read short
    do_prep(2'b00, 7'h10);
    do_read(2'b00, 5, w, miss, oe_end);
    chk("R7 first five response bits", w, 24'h000002);
    chk("R9 oe released on mode change", oe_end, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule